// File: doc/BRIEF.md
# Interleaved Thread Issue Scheduler

This block chooses, on every clock, which of up to eight hardware thread contexts may send one instruction into a shared execution pipeline. Contexts own fixed slots in a rotation: the slot counter steps through all contexts in order, one per cycle. The current slot's context issues when it is enabled, has an instruction ready, is not waiting on a long memory access, and the core is not idling. Any other slot is a bubble. Interleaving threads this way stands in for operand interlocks. A non-memory instruction is fully written back before its context's slot comes round again.

Only one hazard is tracked in hardware. When a context issues a load or store, a per-context pending flag is raised. The flag drops only when the memory system returns that context's ID on the writeback port. While the flag is high, the context's slots are bubbles. Non-memory instructions are represented by tokens in a fixed-latency stub pipeline, and the stub reports each token's writeback. The stub latency EXE_LAT must be smaller than NUM_THR.

Top module: `mt_issue_sched`

## Requirements
- R1: While rst_ni is low, mem_pend_o is all zero, exe_wb_valid_o is 0, and issue_valid_o is 0 when no context is enabled. The first cycle after reset release is slot 0.
- R2: In the k-th cycle after reset release (k counted from 0), issue_tid_o equals k mod NUM_THR, in every cycle, bubbles included.
- R3: issue_valid_o is 1 exactly when, for the slot's context, thr_en_i is 1, thr_rdy_i is 1, and mem_pend_o is 0, with idle_i low. Otherwise the cycle is a bubble with issue_valid_o at 0.
- R4: A context whose thr_en_i bit is 0 never issues, whatever its ready bit.
- R5: An issue with thr_mem_i set for that context drives issue_mem_o high. It sets that context's mem_pend_o bit from the next cycle. The bit stays set until it is cleared, and it blocks the context's slots.
- R6: A cycle with wb_valid_i high and wb_tid_i = t clears mem_pend_o[t] from the next cycle, so t issues again at its next slot. A writeback for a context that is not pending changes no flag.
- R7: While idle_i is high, issue_valid_o stays 0 and the slot rotation keeps advancing.
- R8: A non-memory issue by context t in cycle c produces exe_wb_valid_o = 1 with exe_wb_tid_o = t in cycle c + EXE_LAT. exe_wb_valid_o is 0 in every other cycle.
- R9: No context issues while it still has an instruction in flight, whether a stub token or a pending memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_i | input | 1 | Suppresses all issue; rotation continues |
| thr_en_i | input | NUM_THR | Per-context enable |
| thr_rdy_i | input | NUM_THR | Per-context instruction ready |
| thr_mem_i | input | NUM_THR | Ready instruction is a load or store |
| wb_valid_i | input | 1 | Memory writeback strobe |
| wb_tid_i | input | 3 | Context ID of the memory writeback |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_tid_o | output | 3 | Current slot context ID |
| issue_mem_o | output | 1 | The issued instruction is a memory access |
| mem_pend_o | output | NUM_THR | Per-context memory-pending flags |
| exe_wb_valid_o | output | 1 | Stub pipeline writeback strobe |
| exe_wb_tid_o | output | 3 | Context ID of the stub writeback |

## Verification
issue_valid_o, issue_tid_o and issue_mem_o are combinational, so they are due in the same cycle as the inputs that decide them. mem_pend_o changes one cycle after the setting issue or the clearing writeback. exe_wb_valid_o appears exactly EXE_LAT cycles after the non-memory issue. The driver queues, for each cycle, values computed from a reference model of slot, pending flags and a line of EXE_LAT tokens. The monitor compares them with the outputs at the matching falling clock edge, after the inputs have settled. The monitor also tracks each context's in-flight work from the outputs alone and flags any issue by a busy context.

// File: rtl/mt_issue_pkg.sv
package mt_issue_pkg;
  localparam int unsigned MAX_THR = 8;
  localparam int unsigned TID_W   = $clog2(MAX_THR);

  typedef logic [TID_W-1:0] tid_t;

  typedef struct packed {
    logic vld;
    tid_t tid;
  } tok_t;
endpackage

// File: rtl/mt_rr_slot.sv
module mt_rr_slot
  import mt_issue_pkg::*;
#(
  parameter int unsigned NUM_THR = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output tid_t slot_o
);
  localparam tid_t LAST = tid_t'(NUM_THR - 1);

  tid_t slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + 1'b1;
  end

  assign slot_o = slot_q;

  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1)); // R2
  AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == LAST) |=> (slot_q == '0)); // R2
endmodule

// File: rtl/mt_mem_pend.sv
module mt_mem_pend
  import mt_issue_pkg::*;
#(
  parameter int unsigned NUM_THR = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_vld_i,
  input  tid_t               set_tid_i,
  input  logic               clr_vld_i,
  input  tid_t               clr_tid_i,
  output logic [NUM_THR-1:0] pend_o
);
  logic [NUM_THR-1:0] pend_q;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic set_hit, clr_hit;
    assign set_hit = set_vld_i && (set_tid_i == tid_t'(t));
    assign clr_hit = clr_vld_i && (clr_tid_i == tid_t'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pend_q[t] <= 1'b0;
      else if (set_hit) pend_q[t] <= 1'b1;
      else if (clr_hit) pend_q[t] <= 1'b0;
    end

    AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[t] && !clr_hit) |=> pend_q[t]); // R5
    AST_NO_SET_WHILE_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_hit |-> !pend_q[t]); // R9
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/mt_tok_pipe.sv
module mt_tok_pipe
  import mt_issue_pkg::*;
#(
  parameter int unsigned NUM_THR = 8,
  parameter int unsigned EXE_LAT = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  tok_t               tok_i,
  output tok_t               tok_o,
  output logic [NUM_THR-1:0] busy_o
);
  tok_t stg_q [EXE_LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < EXE_LAT; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= tok_i;
      for (int k = 1; k < EXE_LAT; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  // a context is busy while any of its tokens sits in a stage
  always_comb begin
    busy_o = '0;
    for (int k = 0; k < EXE_LAT; k++)
      if (stg_q[k].vld) busy_o[stg_q[k].tid] = 1'b1;
  end

  assign tok_o = stg_q[EXE_LAT-1];

  AST_ENTRY_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_i.vld |-> !busy_o[tok_i.tid]); // R9
endmodule

// File: rtl/mt_issue_sched.sv
module mt_issue_sched
  import mt_issue_pkg::*;
#(
  parameter int unsigned NUM_THR = 8,
  parameter int unsigned EXE_LAT = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               idle_i,
  input  logic [NUM_THR-1:0] thr_en_i,
  input  logic [NUM_THR-1:0] thr_rdy_i,
  input  logic [NUM_THR-1:0] thr_mem_i,
  input  logic               wb_valid_i,
  input  tid_t               wb_tid_i,
  output logic               issue_valid_o,
  output tid_t               issue_tid_o,
  output logic               issue_mem_o,
  output logic [NUM_THR-1:0] mem_pend_o,
  output logic               exe_wb_valid_o,
  output tid_t               exe_wb_tid_o
);
  tid_t               slot;
  logic [NUM_THR-1:0] pend;
  logic [NUM_THR-1:0] exe_busy;
  logic               can_issue;
  logic               is_mem;
  tok_t               exe_in, exe_out;

  mt_rr_slot #(.NUM_THR(NUM_THR)) i_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot)
  );

  assign can_issue = !idle_i && thr_en_i[slot] && thr_rdy_i[slot] && !pend[slot];
  assign is_mem    = can_issue && thr_mem_i[slot];

  mt_mem_pend #(.NUM_THR(NUM_THR)) i_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_vld_i (is_mem),
    .set_tid_i (slot),
    .clr_vld_i (wb_valid_i),
    .clr_tid_i (wb_tid_i),
    .pend_o    (pend)
  );

  assign exe_in.vld = can_issue && !thr_mem_i[slot];
  assign exe_in.tid = slot;

  mt_tok_pipe #(.NUM_THR(NUM_THR), .EXE_LAT(EXE_LAT)) i_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tok_i  (exe_in),
    .tok_o  (exe_out),
    .busy_o (exe_busy)
  );

  assign issue_valid_o  = can_issue;
  assign issue_tid_o    = slot;
  assign issue_mem_o    = is_mem;
  assign mem_pend_o     = pend;
  assign exe_wb_valid_o = exe_out.vld;
  assign exe_wb_tid_o   = exe_out.tid;

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> !(exe_busy[issue_tid_o] || mem_pend_o[issue_tid_o])); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !issue_valid_o); // R7
  AST_EN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> thr_en_i[issue_tid_o]); // R4
  AST_MEM_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && issue_mem_o) |=> mem_pend_o[$past(issue_tid_o)]); // R5
  AST_WB_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i |=> !mem_pend_o[$past(wb_tid_i)]); // R6
endmodule

// File: tb/test_mt_issue_sched.sv
module test_mt_issue_sched;
  import mt_issue_pkg::*;

  localparam int unsigned NT  = 8;
  localparam int unsigned EL  = 6;
  localparam time         TCK = 20ns;

  logic clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  logic          rst_ni, idle, wbv;
  logic [NT-1:0] en, rdy, mem;
  tid_t          wbt;
  logic          issue_valid, issue_mem, exe_valid;
  tid_t          issue_tid, exe_tid;
  logic [NT-1:0] pend;

  mt_issue_sched #(.NUM_THR(NT), .EXE_LAT(EL)) i_mt_issue_sched (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .idle_i         (idle),
    .thr_en_i       (en),
    .thr_rdy_i      (rdy),
    .thr_mem_i      (mem),
    .wb_valid_i     (wbv),
    .wb_tid_i       (wbt),
    .issue_valid_o  (issue_valid),
    .issue_tid_o    (issue_tid),
    .issue_mem_o    (issue_mem),
    .mem_pend_o     (pend),
    .exe_wb_valid_o (exe_valid),
    .exe_wb_tid_o   (exe_tid)
  );

  typedef struct {
    logic          iv;
    tid_t          tid;
    logic          im;
    logic [NT-1:0] pend;
    logic          ev;
    tid_t          etid;
    string         req;
  } exp_t;

  exp_t          sb[$];
  tok_t          line[$];
  int            n_chk = 0, n_bad = 0;
  tid_t          slot_m;
  logic [NT-1:0] pend_m;
  logic [NT-1:0] infl;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the model's expectation
  task automatic drive(input logic [NT-1:0] d_en, input logic [NT-1:0] d_rdy,
                       input logic [NT-1:0] d_mem, input logic d_idle,
                       input logic d_wbv, input tid_t d_wbt, input string req);
    exp_t e;
    tok_t t;
    @(negedge clk);
    en = d_en; rdy = d_rdy; mem = d_mem; idle = d_idle; wbv = d_wbv; wbt = d_wbt;
    e.iv   = !d_idle && d_en[slot_m] && d_rdy[slot_m] && !pend_m[slot_m];
    e.tid  = slot_m;
    e.im   = e.iv && d_mem[slot_m];
    e.pend = pend_m;
    t      = line.pop_front();
    e.ev   = t.vld;
    e.etid = t.tid;
    e.req  = req;
    sb.push_back(e);
    t.vld = e.iv && !d_mem[slot_m];
    t.tid = slot_m;
    line.push_back(t);
    if (d_wbv) pend_m[d_wbt] = 1'b0;
    if (e.im)  pend_m[slot_m] = 1'b1;
    slot_m = (slot_m == tid_t'(NT-1)) ? '0 : slot_m + 1'b1;
  endtask

  // monitor: compares outputs against queued expectations
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(e.req, "issue_valid", int'(issue_valid), int'(e.iv));
        chk("R2",  "issue_tid",   int'(issue_tid),   int'(e.tid));
        chk("R5",  "issue_mem",   int'(issue_mem),   int'(e.im));
        chk("R6",  "mem_pend",    int'(pend),        int'(e.pend));
        chk("R8",  "exe_valid",   int'(exe_valid),   int'(e.ev));
        if (e.ev) chk("R8", "exe_tid", int'(exe_tid), int'(e.etid));
        if (issue_valid) chk("R9", "busy_at_issue", int'(infl[issue_tid]), 0);
        if (exe_valid) infl[exe_tid] = 1'b0;
        if (wbv)       infl[wbt]     = 1'b0;
        if (issue_valid) infl[issue_tid] = 1'b1;
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(TCK * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog act=1 exp=0");
    summary();
  end

  initial begin
    rst_ni = 1'b0; idle = 1'b0; wbv = 1'b0; wbt = '0;
    en = '0; rdy = '0; mem = '0;
    slot_m = '0; pend_m = '0; infl = '0;
    for (int k = 0; k < EL; k++) line.push_back('0);

    repeat (3) @(negedge clk);
    #2;
    chk("R1", "reset_pend",  int'(pend),        0);
    chk("R1", "reset_exe",   int'(exe_valid),   0);
    chk("R1", "reset_issue", int'(issue_valid), 0);
    chk("R1", "reset_slot",  int'(issue_tid),   0);
    @(posedge clk);
    #1 rst_ni = 1'b1;

    // all contexts active, no memory ops
    for (int i = 0; i < 20; i++) drive('1, '1, '0, 1'b0, 1'b0, '0, "R2");
    // some contexts disabled but ready
    for (int i = 0; i < 16; i++) drive(8'b0110_1101, '1, '0, 1'b0, 1'b0, '0, "R4");
    // varying ready pattern
    for (int i = 0; i < 16; i++) drive('1, 8'(i * 37 + 5), '0, 1'b0, 1'b0, '0, "R3");
    // context 2 issues loads; stray writeback to 5; clear twice
    for (int i = 0; i < 30; i++)
      drive('1, '1, 8'b0000_0100, 1'b0, (i == 12) || (i == 20) || (i == 26),
            (i == 12) ? tid_t'(5) : tid_t'(2), "R5");
    // idle window, then resume
    for (int i = 0; i < 11; i++) drive('1, '1, '0, 1'b1, 1'b0, '0, "R7");
    for (int i = 0; i < 10; i++) drive('1, '1, '0, 1'b0, 1'b0, '0, "R7");
    // drain the stub
    for (int i = 0; i < EL + 2; i++) drive('0, '0, '0, 1'b0, 1'b0, '0, "R8");

    @(negedge clk);
    #3;
    summary();
  end
endmodule